// File: doc/BRIEF.md
# Conditional Branch Evaluator

This block decides, within one combinational pass, whether a relative branch is taken. It also produces every address the fetch stage could need next. Its inputs are a 4-bit condition field, the four status flags (negative, zero, overflow, carry), the address of the branch instruction and a signed 8-bit displacement. It returns the taken decision, the fall-through address, the branch target and the selected next program counter.

The one condition field covers several families of tests on the same flags. There are unsigned magnitude tests, signed magnitude tests, equality tests, tests of a single flag, and a pair of unconditional codes, one always taken and one never taken. Codes are laid out in complementary pairs: an odd code is the exact inverse of the even code just below it. The evaluator only reads the flags and never produces flag updates. The fall-through address is the branch address plus the branch length, which is 2 bytes by default. The target is the fall-through address plus the sign-extended displacement. All address arithmetic wraps modulo 2^16.

Top module: `br_eval`

## Requirements
- R1: For every flag combination, condition code 2k+1 gives the opposite taken decision to condition code 2k (k = 0..7).
- R2: Code 0 (always) is taken for all flag values. Code 1 (never) is never taken, and then the next PC equals the fall-through address.
- R3: Code 2 (unsigned higher) is taken when C=0 and Z=0. Code 3 (unsigned lower-or-same) is taken when C=1 or Z=1.
- R4: Code 4 (unsigned higher-or-same, also used as carry clear) is taken when C=0. Code 5 (unsigned lower, also used as carry set) is taken when C=1.
- R5: Code 6 (not equal) is taken when Z=0. Code 7 (equal) is taken when Z=1.
- R6: Code 8 is taken when V=0 and code 9 when V=1. Code 10 (plus) is taken when N=0 and code 11 (minus) when N=1.
- R7: Code 12 (signed greater-or-equal) is taken when N equals V. Code 13 (signed less) is taken when N differs from V.
- R8: Code 14 (signed greater) is taken when Z=0 and N equals V. Code 15 (signed less-or-equal) is taken when Z=1 or N differs from V.
- R9: fallthru_o equals pc_i + 2 modulo 2^16.
- R10: target_o equals fallthru_o plus the 8-bit offset_i sign-extended to 16 bits, modulo 2^16, whatever the taken decision.
- R11: next_pc_o equals target_o when taken_o is 1 and fallthru_o otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cond_i | input | 4 | Branch condition code (encoding in R1 to R8) |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_v_i | input | 1 | Overflow flag |
| flag_c_i | input | 1 | Carry flag |
| pc_i | input | 16 | Address of the branch instruction |
| offset_i | input | 8 | Signed two's-complement displacement |
| taken_o | output | 1 | Branch decision |
| fallthru_o | output | 16 | Address of the following instruction |
| target_o | output | 16 | Branch destination address |
| next_pc_o | output | 16 | Selected next program counter |

## Verification
The decision logic is swept over all 16 codes against all 16 flag combinations. Comparing each result with a per-code model separates the unsigned tests from the signed ones: for example, C=1 with N=V takes signed greater but not unsigned higher. It also separates equality from magnitude, because Z alone flips codes 6, 7, 14 and 15. A pair sweep confirms that every odd code inverts its even partner. Address vectors use the extreme displacements +127 and -128, a displacement of -2 that branches to itself, and branch addresses near 0xFFFF and 0x0000, so wrap-around in both directions is exercised.

// File: rtl/br_eval_pkg.sv
// Package br_eval_pkg
// Shared condition-code encoding and flag bundle for the branch evaluator.
// Assumes a 4-bit condition field whose low bit inverts the predicate
// chosen by the upper bits.
package br_eval_pkg;

    typedef enum logic [3:0] {
        BRC_ALWAYS  = 4'd0,
        BRC_NEVER   = 4'd1,
        BRC_UHI     = 4'd2,
        BRC_ULS     = 4'd3,
        BRC_UHS     = 4'd4,
        BRC_ULO     = 4'd5,
        BRC_NE      = 4'd6,
        BRC_EQ      = 4'd7,
        BRC_VCLR    = 4'd8,
        BRC_VSET    = 4'd9,
        BRC_PLUS    = 4'd10,
        BRC_MINUS   = 4'd11,
        BRC_SGE     = 4'd12,
        BRC_SLT     = 4'd13,
        BRC_SGT     = 4'd14,
        BRC_SLE     = 4'd15
    } brc_code_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } brc_flags_t;

    localparam int unsigned BRC_CODE_W = 4;

endpackage

// File: rtl/br_flag_tests.sv
// Module br_flag_tests
// Computes the eight base predicates, one for each complementary code pair.
// Slot k holds the predicate of even code 2k. Purely combinational.
// Assumes NUM_PRED is 8; extra slots read as 0.
module br_flag_tests
    import br_eval_pkg::*;
#(
    parameter int unsigned NUM_PRED = 8
) (
    input  brc_flags_t          flags_i,
    output logic [NUM_PRED-1:0] pred_o
);

    logic sgn_mismatch;

    // Signed-ordering term shared by the signed tests.
    always_comb sgn_mismatch = flags_i.n ^ flags_i.v;

    // Fill each base-predicate slot from the flags.
    always_comb begin
        pred_o = '0;
        for (int k = 0; k < int'(NUM_PRED); k++) begin
            unique case (k)
                0: pred_o[k] = 1'b1;
                1: pred_o[k] = ~(flags_i.c | flags_i.z);
                2: pred_o[k] = ~flags_i.c;
                3: pred_o[k] = ~flags_i.z;
                4: pred_o[k] = ~flags_i.v;
                5: pred_o[k] = ~flags_i.n;
                6: pred_o[k] = ~sgn_mismatch;
                7: pred_o[k] = ~(flags_i.z | sgn_mismatch);
                default: pred_o[k] = 1'b0;
            endcase
        end
    end

    // Cross-slot consistency checks.
    always_comb begin
        AST_SGT_WITHIN_SGE: assert (!(pred_o[7] && !pred_o[6]));     // R8
        AST_UHI_WITHIN_UHS: assert (!(pred_o[1] && !pred_o[2]));     // R3
        AST_UHI_NEEDS_NE:   assert (!(pred_o[1] && !pred_o[3]));     // R3
    end

endmodule

// File: rtl/br_cond_select.sv
// Module br_cond_select
// Picks the base predicate addressed by the upper code bits and inverts it
// when the code's low bit is set. Purely combinational.
// Assumes the predicate vector is ordered as in br_flag_tests.
module br_cond_select
    import br_eval_pkg::*;
#(
    parameter int unsigned CODE_W = BRC_CODE_W,
    localparam int unsigned NUM_PRED = 2 ** (CODE_W - 1)
) (
    input  logic [CODE_W-1:0]   code_i,
    input  logic [NUM_PRED-1:0] pred_i,
    input  brc_flags_t          flags_i,
    output logic                taken_o
);

    logic chosen;

    // Select the pair predicate by the upper code bits.
    always_comb chosen = pred_i[code_i[CODE_W-1:1]];

    // Apply the pair inversion bit.
    always_comb taken_o = chosen ^ code_i[0];

    // Decisions checked against the raw flags.
    always_comb begin
        AST_ALWAYS_TAKEN: assert (!(code_i == CODE_W'(BRC_ALWAYS)) || taken_o);            // R2
        AST_NEVER_IDLE:   assert (!(code_i == CODE_W'(BRC_NEVER)) || !taken_o);            // R2
        AST_EQ_NEEDS_Z:   assert (!(code_i == CODE_W'(BRC_EQ) && taken_o) || flags_i.z);   // R5
        AST_SGT_NO_Z:     assert (!(code_i == CODE_W'(BRC_SGT) && taken_o) || !flags_i.z); // R8
        AST_ULO_NEEDS_C:  assert (!(code_i == CODE_W'(BRC_ULO) && taken_o) || flags_i.c);  // R4
    end

endmodule

// File: rtl/br_target_calc.sv
// Module br_target_calc
// Forms the fall-through address (branch address plus instruction length)
// and the target (fall-through plus sign-extended displacement). Addresses
// wrap at 2**ADDR_W. Assumes ADDR_W > OFS_W.
module br_target_calc #(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFS_W  = 8,
    parameter int unsigned BR_LEN = 2,
    localparam int unsigned EXT_W = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFS_W-1:0]  offset_i,
    output logic [ADDR_W-1:0] fallthru_o,
    output logic [ADDR_W-1:0] target_o
);

    logic [ADDR_W-1:0] ofs_ext;

    // Step past the branch instruction.
    always_comb fallthru_o = pc_i + ADDR_W'(BR_LEN);

    // Sign-extend the displacement to address width.
    always_comb ofs_ext = {{EXT_W{offset_i[OFS_W-1]}}, offset_i};

    // Add the displacement with modular wrap.
    always_comb target_o = fallthru_o + ofs_ext;

    // Distance relations between the two addresses.
    always_comb begin
        AST_ZERO_OFS_SAME: assert (!(offset_i == '0) || target_o == fallthru_o);        // R10
        AST_SELF_LOOP:     assert (!(offset_i == OFS_W'(-BR_LEN)) || target_o == pc_i); // R10
    end

endmodule

// File: rtl/br_eval.sv
// Module br_eval
// Top of the conditional branch evaluator. It decides taken or not-taken
// from the condition code and flags, computes the fall-through and target
// addresses, and selects the next program counter. Fully combinational:
// no clock and no reset, and no flags are written.
module br_eval
    import br_eval_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned OFS_W  = 8,
    parameter int unsigned BR_LEN = 2,
    localparam int unsigned CODE_W   = BRC_CODE_W,
    localparam int unsigned NUM_PRED = 2 ** (CODE_W - 1)
) (
    input  logic [CODE_W-1:0] cond_i,
    input  logic              flag_n_i,
    input  logic              flag_z_i,
    input  logic              flag_v_i,
    input  logic              flag_c_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFS_W-1:0]  offset_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] fallthru_o,
    output logic [ADDR_W-1:0] target_o,
    output logic [ADDR_W-1:0] next_pc_o
);

    brc_flags_t          flags;
    logic [NUM_PRED-1:0] pred;

    // Bundle the flag pins.
    always_comb flags = '{n: flag_n_i, z: flag_z_i, v: flag_v_i, c: flag_c_i};

    br_flag_tests #(
        .NUM_PRED (NUM_PRED)
    ) u_tests (
        .flags_i (flags),
        .pred_o  (pred)
    );

    br_cond_select #(
        .CODE_W (CODE_W)
    ) u_select (
        .code_i  (cond_i),
        .pred_i  (pred),
        .flags_i (flags),
        .taken_o (taken_o)
    );

    br_target_calc #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W),
        .BR_LEN (BR_LEN)
    ) u_target (
        .pc_i       (pc_i),
        .offset_i   (offset_i),
        .fallthru_o (fallthru_o),
        .target_o   (target_o)
    );

    // Choose where fetch continues.
    always_comb next_pc_o = taken_o ? target_o : fallthru_o;

    // Next-PC relations across submodules.
    always_comb begin
        AST_NEXT_IN_SET:   assert (next_pc_o == target_o || next_pc_o == fallthru_o);                 // R11
        AST_NEVER_FALLS:   assert (!(cond_i == CODE_W'(BRC_NEVER)) || next_pc_o == fallthru_o);      // R2
        AST_ALWAYS_JUMPS:  assert (!(cond_i == CODE_W'(BRC_ALWAYS)) || next_pc_o == target_o);       // R2
    end

endmodule

// File: tb/br_eval_test.sv
module br_eval_test;

    logic        clk = 1'b0;
    logic [3:0]  cond;
    logic        fn, fz, fv, fc;
    logic [15:0] pc;
    logic [7:0]  ofs;
    logic        taken;
    logic [15:0] fallthru, target, next_pc;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    br_eval uut (
        .cond_i     (cond),
        .flag_n_i   (fn),
        .flag_z_i   (fz),
        .flag_v_i   (fv),
        .flag_c_i   (fc),
        .pc_i       (pc),
        .offset_i   (ofs),
        .taken_o    (taken),
        .fallthru_o (fallthru),
        .target_o   (target),
        .next_pc_o  (next_pc)
    );

    function automatic logic model_taken(input int code, input logic n, input logic z,
                                         input logic v, input logic c);
        case (code)
            0:  return 1'b1;
            1:  return 1'b0;
            2:  return !c && !z;
            3:  return c || z;
            4:  return !c;
            5:  return c;
            6:  return !z;
            7:  return z;
            8:  return !v;
            9:  return v;
            10: return !n;
            11: return n;
            12: return n == v;
            13: return n != v;
            14: return !z && (n == v);
            default: return z || (n != v);
        endcase
    endfunction

    function automatic string req_of(input int code);
        if (code < 2)  return "R2";
        if (code < 4)  return "R3";
        if (code < 6)  return "R4";
        if (code < 8)  return "R5";
        if (code < 12) return "R6";
        if (code < 14) return "R7";
        return "R8";
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input int code, input logic [3:0] nzvc,
                         input logic [15:0] p, input logic [7:0] o);
        @(negedge clk);
        cond = 4'(code);
        {fn, fz, fv, fc} = nzvc;
        pc = p;
        ofs = o;
        #1;
    endtask

    // Directed: unconditional pair (R2)
    task automatic t_unconditional();
        for (int f = 0; f < 16; f++) begin
            apply(0, 4'(f), 16'h4000, 8'h10);
            check("R2", "always taken", {15'd0, taken}, 16'd1);
            apply(1, 4'(f), 16'h4000, 8'h10);
            check("R2", "never taken", {15'd0, taken}, 16'd0);
            check("R2", "never next_pc", next_pc, 16'h4002);
        end
    endtask

    // Directed: unsigned versus signed distinguishing vectors (R3, R8)
    task automatic t_sign_vs_unsigned();
        apply(2, 4'b0001, 16'h0100, 8'h00);      // C=1 N=V=0
        check("R3", "higher with C=1", {15'd0, taken}, 16'd0);
        apply(14, 4'b0001, 16'h0100, 8'h00);
        check("R8", "greater with C=1", {15'd0, taken}, 16'd1);
        apply(2, 4'b1000, 16'h0100, 8'h00);      // N=1 V=0
        check("R3", "higher with N^V", {15'd0, taken}, 16'd1);
        apply(14, 4'b1000, 16'h0100, 8'h00);
        check("R8", "greater with N^V", {15'd0, taken}, 16'd0);
        apply(15, 4'b0100, 16'h0100, 8'h00);
        check("R8", "less-or-equal with Z", {15'd0, taken}, 16'd1);
        apply(4, 4'b0100, 16'h0100, 8'h00);
        check("R4", "higher-or-same with Z only", {15'd0, taken}, 16'd1);
    endtask

    // Sweep: every code against every flag combination (R2..R8, R11)
    task automatic t_sweep();
        for (int code = 0; code < 16; code++) begin
            for (int f = 0; f < 16; f++) begin
                logic [3:0] nzvc;
                logic       exp;
                nzvc = 4'(f);
                exp = model_taken(code, nzvc[3], nzvc[2], nzvc[1], nzvc[0]);
                apply(code, nzvc, 16'h8000, 8'hF0);
                check(req_of(code), $sformatf("code %0d flags %b", code, nzvc),
                      {15'd0, taken}, {15'd0, exp});
                check("R11", "next_pc select", next_pc, exp ? 16'h7FF2 : 16'h8002);
            end
        end
    endtask

    // Sweep: odd code inverts even partner (R1)
    task automatic t_pairs();
        for (int k = 0; k < 8; k++) begin
            for (int f = 0; f < 16; f++) begin
                logic even_t;
                apply(2 * k, 4'(f), 16'h0000, 8'h00);
                even_t = taken;
                apply(2 * k + 1, 4'(f), 16'h0000, 8'h00);
                check("R1", $sformatf("pair %0d flags %0d", k, f),
                      {15'd0, taken}, {15'd0, ~even_t});
            end
        end
    endtask

    // Directed: address arithmetic and wrap (R9, R10)
    task automatic t_addresses();
        logic [15:0] pcs  [5] = '{16'hFFFE, 16'h0000, 16'h1234, 16'h1234, 16'hFFFF};
        logic [7:0]  ofss [5] = '{8'h05,    8'h80,    8'h7F,    8'hFE,    8'h01};
        for (int i = 0; i < 5; i++) begin
            logic [15:0] ft, tg;
            ft = pcs[i] + 16'd2;
            tg = ft + {{8{ofss[i][7]}}, ofss[i]};
            apply(1, 4'b0000, pcs[i], ofss[i]);   // never taken: target still formed
            check("R9", "fall-through", fallthru, ft);
            check("R10", "target when not taken", target, tg);
            apply(0, 4'b0000, pcs[i], ofss[i]);
            check("R10", "target when taken", target, tg);
            check("R11", "next_pc taken", next_pc, tg);
        end
        apply(0, 4'b0000, 16'h0000, 8'h80);
        check("R10", "backward wrap to 0xFF82", target, 16'hFF82);
        apply(0, 4'b0000, 16'h1234, 8'hFE);
        check("R10", "branch to self", target, 16'h1234);
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        cond = '0; {fn, fz, fv, fc} = '0; pc = '0; ofs = '0;
        repeat (2) @(posedge clk);
        t_unconditional();
        t_sign_vs_unsigned();
        t_sweep();
        t_pairs();
        t_addresses();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule